// File: doc/BRIEF.md
# MMU Fault Status Capture Unit

This unit sits beside a page-table walker and keeps a record of the most recent translation fault. When the walker reports a fault, the unit latches the faulting virtual address and builds a status word. The status word holds the fault type, the walk level at which the fault was found and an encoding of the access that caused it. In the same cycle it decides whether the processor takes a trap.

Trap selection works as follows. A faulting instruction fetch raises an instruction-access trap, and any other faulting access raises a data-access trap. No trap is raised while the no-fault mode is on or while traps are disabled. In that case the unit instead pulses a grant that lets the access continue with read and write permission.

Software reads the two registers through a small read port. Reading the status register clears it. If a second fault arrives while the status register still holds an unread value, the old contents are discarded and the new status is marked with an overflow flag.

Top module: `fsc_unit`

## Requirements
- R1: After reset the status register and the address register both read as zero, and itrap_o, dtrap_o, grant_rw_o and rd_valid_o are low.
- R2: A fault that finds the status register at zero stores a status word with these bits: bit 1 is set (address valid), bit 0 is clear, bits 4:2 hold the fault type, bits 7:5 hold the access index and bits 9:8 hold the walk level. All higher bits are zero.
- R3: A fault that finds the status register nonzero, with no clearing read in the same cycle, replaces the register with 1 (the overflow flag in bit 0). The fields of the new fault are then ORed in, together with bit 1. No field of the older fault survives.
- R4: Every fault loads the full faulting virtual address into the address register. A read of the address register leaves both registers unchanged.
- R5: A fault with no_fault_mode_i high or trap_en_i low raises neither trap and pulses grant_rw_o for one cycle, in the cycle after the fault.
- R6: In every other case, a fault raises a one-cycle pulse in the cycle after the fault. The pulse is on itrap_o when acc_fetch_i is high and on dtrap_o otherwise. At most one of itrap_o, dtrap_o and grant_rw_o is high in any cycle.
- R7: The access index is {write, fetch, supervisor}: write at bit 7, fetch at bit 6, supervisor at bit 5.
- R8: A read with rd_sel_i = 0 selects the status register and rd_sel_i = 1 selects the address register. The read data appears with rd_valid_o one cycle after rd_en_i. A status read returns the value before the read and clears the register to zero in that same cycle.
- R9: When a fault and a clearing status read fall in the same cycle, the read returns the old status. The register then holds the new fault's status with the overflow bit clear.
- R10: A cycle without a fault is followed by a cycle with itrap_o, dtrap_o and grant_rw_o all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flt_valid_i | input | 1 | Walker reports a fault this cycle |
| flt_addr_i | input | VA_W | Faulting virtual address |
| flt_type_i | input | 3 | Fault type code |
| flt_level_i | input | 2 | Walk level where the fault was found |
| acc_write_i | input | 1 | Faulting access is a write |
| acc_fetch_i | input | 1 | Faulting access is an instruction fetch |
| acc_super_i | input | 1 | Faulting access is in supervisor mode |
| no_fault_mode_i | input | 1 | No-fault mode is on |
| trap_en_i | input | 1 | Traps are enabled |
| rd_en_i | input | 1 | Software read request |
| rd_sel_i | input | 1 | Read select: 0 status, 1 address |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | VA_W | Read data; the status word is zero-extended |
| itrap_o | output | 1 | Instruction-access trap pulse |
| dtrap_o | output | 1 | Data-access trap pulse |
| grant_rw_o | output | 1 | Access continues with read and write permission |

## Verification
A fault capture and a clearing status read can fall in the same clock cycle. The bench provokes this with a single operation that raises flt_valid_i and a status read together while the register still holds an older, unread fault. The check has two parts. First, the read must return that older word. Second, a later read must show the new fault's fields without the overflow bit, which separates this case from the plain overflow case that the bench runs just before it.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int TYPE_W   = 3;
  localparam int LEVEL_W  = 2;
  localparam int ACC_W    = 3;
  localparam int OVF_BIT  = 0;
  localparam int FAV_BIT  = 1;
  localparam int TYPE_LSB = 2;
  localparam int ACC_LSB  = TYPE_LSB + TYPE_W;
  localparam int LVL_LSB  = ACC_LSB + ACC_W;
  localparam int STATUS_W = LVL_LSB + LEVEL_W;

  typedef logic [STATUS_W-1:0] status_t;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_ADDR   = 1'b1
  } rd_sel_e;

  function automatic status_t pack_fields(
    input logic [TYPE_W-1:0]  ftype,
    input logic [LEVEL_W-1:0] lvl,
    input logic               wr,
    input logic               fetch,
    input logic               sup
  );
    status_t s;
    s = '0;
    s[TYPE_LSB +: TYPE_W]  = ftype;
    s[ACC_LSB +: ACC_W]    = {wr, fetch, sup};
    s[LVL_LSB +: LEVEL_W]  = lvl;
    s[FAV_BIT]             = 1'b1;
    return s;
  endfunction
endpackage

// File: rtl/fsc_status_reg.sv
module fsc_status_reg
  import fsc_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    flt_i,
  input  status_t rec_i,
  input  logic    clr_i,
  output status_t status_o
);
  status_t status_q;
  status_t base;

  // an unread old value collapses to the overflow flag; a same-cycle clear services it
  always_comb begin
    base = '0;
    if (status_q != '0 && !clr_i) base[OVF_BIT] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    status_q <= '0;
    else if (flt_i) status_q <= base | rec_i;
    else if (clr_i) status_q <= '0;
  end

  assign status_o = status_q;
endmodule

// File: rtl/fsc_addr_reg.sv
module fsc_addr_reg #(
  parameter int VA_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flt_i,
  input  logic [VA_W-1:0] addr_i,
  output logic [VA_W-1:0] addr_o
);
  logic [VA_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    addr_q <= '0;
    else if (flt_i) addr_q <= addr_i;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/fsc_trap_ctl.sv
module fsc_trap_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flt_i,
  input  logic fetch_i,
  input  logic no_fault_i,
  input  logic trap_en_i,
  output logic itrap_o,
  output logic dtrap_o,
  output logic grant_o
);
  logic suppress;
  logic itrap_q, dtrap_q, grant_q;

  assign suppress = no_fault_i | ~trap_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      itrap_q <= 1'b0;
      dtrap_q <= 1'b0;
      grant_q <= 1'b0;
    end else begin
      itrap_q <= flt_i & ~suppress &  fetch_i;
      dtrap_q <= flt_i & ~suppress & ~fetch_i;
      grant_q <= flt_i &  suppress;
    end
  end

  assign itrap_o = itrap_q;
  assign dtrap_o = dtrap_q;
  assign grant_o = grant_q;
endmodule

// File: rtl/fsc_read_port.sv
module fsc_read_port
  import fsc_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rd_en_i,
  input  logic            rd_sel_i,
  input  status_t         status_i,
  input  logic [VA_W-1:0] addr_i,
  output logic            clr_o,
  output logic            rd_valid_o,
  output logic [VA_W-1:0] rd_data_o
);
  localparam int PAD_W = VA_W - STATUS_W;

  logic            valid_q;
  logic [VA_W-1:0] data_q;
  logic [VA_W-1:0] sel_data;

  always_comb begin
    if (rd_sel_e'(rd_sel_i) == SEL_ADDR) sel_data = addr_i;
    else                                 sel_data = {{PAD_W{1'b0}}, status_i};
  end

  assign clr_o = rd_en_i & (rd_sel_e'(rd_sel_i) == SEL_STATUS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= rd_en_i;
      if (rd_en_i) data_q <= sel_data;
    end
  end

  assign rd_valid_o = valid_q;
  assign rd_data_o  = data_q;
endmodule

// File: rtl/fsc_unit.sv
module fsc_unit
  import fsc_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 flt_valid_i,
  input  logic [VA_W-1:0]      flt_addr_i,
  input  logic [TYPE_W-1:0]    flt_type_i,
  input  logic [LEVEL_W-1:0]   flt_level_i,
  input  logic                 acc_write_i,
  input  logic                 acc_fetch_i,
  input  logic                 acc_super_i,
  input  logic                 no_fault_mode_i,
  input  logic                 trap_en_i,
  input  logic                 rd_en_i,
  input  logic                 rd_sel_i,
  output logic                 rd_valid_o,
  output logic [VA_W-1:0]      rd_data_o,
  output logic                 itrap_o,
  output logic                 dtrap_o,
  output logic                 grant_rw_o
);
  status_t         rec;
  status_t         status_q;
  logic [VA_W-1:0] addr_q;
  logic            clr;

  assign rec = pack_fields(flt_type_i, flt_level_i, acc_write_i, acc_fetch_i, acc_super_i);

  fsc_status_reg u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flt_i    (flt_valid_i),
    .rec_i    (rec),
    .clr_i    (clr),
    .status_o (status_q)
  );

  fsc_addr_reg #(.VA_W(VA_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flt_i  (flt_valid_i),
    .addr_i (flt_addr_i),
    .addr_o (addr_q)
  );

  fsc_trap_ctl u_trap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flt_i      (flt_valid_i),
    .fetch_i    (acc_fetch_i),
    .no_fault_i (no_fault_mode_i),
    .trap_en_i  (trap_en_i),
    .itrap_o    (itrap_o),
    .dtrap_o    (dtrap_o),
    .grant_o    (grant_rw_o)
  );

  fsc_read_port #(.VA_W(VA_W)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_en_i),
    .rd_sel_i   (rd_sel_i),
    .status_i   (status_q),
    .addr_i     (addr_q),
    .clr_o      (clr),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o)
  );
endmodule

// File: rtl/fsc_unit_chk.sv
module fsc_unit_chk
  import fsc_pkg::*;
#(
  parameter int VA_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            flt_valid_i,
  input logic [VA_W-1:0] flt_addr_i,
  input logic            acc_fetch_i,
  input logic            no_fault_mode_i,
  input logic            trap_en_i,
  input logic            rd_en_i,
  input logic            rd_sel_i,
  input logic            itrap_o,
  input logic            dtrap_o,
  input logic            grant_rw_o,
  input status_t         status_q,
  input logic [VA_W-1:0] addr_q
);
  logic rd_stat;
  assign rd_stat = rd_en_i & ~rd_sel_i;

  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_valid_i && status_q != '0 && !rd_stat |=> status_q[OVF_BIT] && status_q[FAV_BIT]);

  // R9
  same_cycle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_valid_i && rd_stat |=> !status_q[OVF_BIT] && status_q[FAV_BIT]);

  // R4
  addr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_valid_i |=> addr_q == $past(flt_addr_i));

  // R8
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stat && !flt_valid_i |=> status_q == '0);

  // R5
  suppress_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_valid_i && (no_fault_mode_i || !trap_en_i) |=> grant_rw_o && !itrap_o && !dtrap_o);

  // R6
  fetch_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_valid_i && !no_fault_mode_i && trap_en_i && acc_fetch_i |=> itrap_o);

  // R6
  trap_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({itrap_o, dtrap_o, grant_rw_o}));

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flt_valid_i |=> !itrap_o && !dtrap_o && !grant_rw_o);
endmodule

bind fsc_unit fsc_unit_chk #(.VA_W(VA_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .flt_valid_i     (flt_valid_i),
  .flt_addr_i      (flt_addr_i),
  .acc_fetch_i     (acc_fetch_i),
  .no_fault_mode_i (no_fault_mode_i),
  .trap_en_i       (trap_en_i),
  .rd_en_i         (rd_en_i),
  .rd_sel_i        (rd_sel_i),
  .itrap_o         (itrap_o),
  .dtrap_o         (dtrap_o),
  .grant_rw_o      (grant_rw_o),
  .status_q        (status_q),
  .addr_q          (addr_q)
);

// File: tb/fsc_unit_test.sv
`timescale 1ns/100ps
module fsc_unit_test;
  localparam int VA_W = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            flt_valid = 1'b0;
  logic [VA_W-1:0] flt_addr = '0;
  logic [2:0]      flt_type = '0;
  logic [1:0]      flt_level = '0;
  logic            acc_write = 1'b0, acc_fetch = 1'b0, acc_super = 1'b0;
  logic            no_fault = 1'b0, trap_en = 1'b0;
  logic            rd_en = 1'b0, rd_sel = 1'b0;
  logic            rd_valid;
  logic [VA_W-1:0] rd_data;
  logic            itrap, dtrap, grant;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  fsc_unit #(.VA_W(VA_W)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .flt_valid_i(flt_valid), .flt_addr_i(flt_addr), .flt_type_i(flt_type),
    .flt_level_i(flt_level), .acc_write_i(acc_write), .acc_fetch_i(acc_fetch),
    .acc_super_i(acc_super), .no_fault_mode_i(no_fault), .trap_en_i(trap_en),
    .rd_en_i(rd_en), .rd_sel_i(rd_sel), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .itrap_o(itrap), .dtrap_o(dtrap), .grant_rw_o(grant)
  );

  typedef struct {
    bit          is_read;
    logic [31:0] val;
    string       req;
  } exp_t;

  exp_t exp_q[$];

  logic [31:0] m_status = '0;
  logic [31:0] m_addr   = '0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // trap value {itrap, dtrap, grant}
  task automatic do_op(input logic flt, input logic [31:0] addr, input logic [2:0] ty,
                       input logic [1:0] lvl, input logic wr, input logic fe, input logic su,
                       input logic nf, input logic te, input logic rd, input logic sel,
                       input string req);
    exp_t e;
    logic [31:0] fields;
    logic        clr;
    clr = rd && !sel;
    fields = {22'd0, lvl, wr, fe, su, ty, 2'b10};
    if (flt) begin
      e.is_read = 1'b0;
      e.req = req;
      if (nf || !te) e.val = 32'b001;
      else if (fe)   e.val = 32'b100;
      else           e.val = 32'b010;
      exp_q.push_back(e);
    end
    if (rd) begin
      e.is_read = 1'b1;
      e.req = req;
      e.val = sel ? m_addr : m_status;
      exp_q.push_back(e);
    end
    if (flt) begin
      m_status = ((m_status != 0 && !clr) ? 32'd1 : 32'd0) | fields;
      m_addr   = addr;
    end else if (clr) begin
      m_status = '0;
    end
    @(posedge clk); #1;
    flt_valid = flt; flt_addr = addr; flt_type = ty; flt_level = lvl;
    acc_write = wr; acc_fetch = fe; acc_super = su; no_fault = nf; trap_en = te;
    rd_en = rd; rd_sel = sel;
    @(posedge clk); #1;
    flt_valid = 1'b0; rd_en = 1'b0;
  endtask

  task automatic rd_op(input logic sel, input string req);
    do_op(1'b0, '0, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, sel, req);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (itrap || dtrap || grant) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R10: actual trap %b%b%b expected none", itrap, dtrap, grant);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check({e.req, " trap"}, {29'd0, itrap, dtrap, grant}, e.is_read ? 32'hffffffff : e.val);
        end
      end
      if (rd_valid) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R8: actual read %h expected none", rd_data);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check({e.req, " read"}, rd_data, e.is_read ? e.val : 32'hffffffff);
        end
      end
    end
  end

  task automatic finish_run();
    check("queue drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 outputs", {28'd0, itrap, dtrap, grant, rd_valid}, 32'd0);
    rd_op(1'b0, "R1");
    rd_op(1'b1, "R1");
    // R2 R6 R7: data read, user, traps on
    do_op(1'b1, 32'hdead_b000, 3'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
    rd_op(1'b1, "R4");
    rd_op(1'b0, "R2");
    rd_op(1'b0, "R8");
    // fetch, supervisor: instruction trap
    do_op(1'b1, 32'h0040_1234, 3'd4, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
    // write on top of unread status: overflow
    do_op(1'b1, 32'h8000_0ffc, 3'd2, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R7");
    rd_op(1'b1, "R4");
    rd_op(1'b0, "R3");
    rd_op(1'b0, "R8");
    // R5: no-fault mode, then traps disabled
    do_op(1'b1, 32'h1111_2222, 3'd3, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R5");
    do_op(1'b1, 32'h3333_4444, 3'd5, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
    rd_op(1'b0, "R3");
    // R9: fault and clearing read together on a nonzero status
    do_op(1'b1, 32'h5555_6000, 3'd6, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
    do_op(1'b1, 32'h7777_8000, 3'd7, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R9");
    rd_op(1'b0, "R9");
    rd_op(1'b1, "R4");
    // R10: idle cycles raise nothing
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R10 idle", {29'd0, itrap, dtrap, grant}, 32'd0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule